// File: doc/BRIEF.md
# Multi-Cycle Integer Divider

This block divides a double-width dividend by a single-width divisor. One datapath covers two widths, 16-by-8 and 32-by-16, and two modes, signed and unsigned. An execution controller places the operands on the inputs and raises `start_i` for one cycle. It then waits for `done_o` and takes the quotient and the remainder from two separate result ports. Because the two results sit on separate ports, the controller can write them back in two consecutive cycles.

The engine is a restoring shift-subtract loop. It produces one quotient bit per cycle. Signed operands are first turned into magnitudes, and the signs are put back after the loop. Results that cannot be represented raise `fault_o` instead of giving a value. This covers a zero divisor and a quotient outside the range of the result width. Handling the fault belongs to the controller.

Top module: `int_div_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `fault_o` are 0, and `quot_o` and `rem_o` are 0.
- R2: A `start_i` sampled while idle sets `busy_o` from the next cycle. Let N be 8 in narrow mode (`wide_i`=0) and 16 in wide mode. `done_o` is 1 for exactly one cycle, N+1 cycles after the start edge. In that same cycle `busy_o` returns to 0.
- R3: A `start_i` that arrives while `busy_o` is 1 is ignored. The running operation completes with its original operands and timing.
- R4: Narrow unsigned mode divides `dividend_i[15:0]` by `divisor_i[7:0]`. The quotient appears in `quot_o[7:0]` and the remainder in `rem_o[7:0]`. Bits [15:8] of both result ports are 0.
- R5: Wide unsigned mode divides `dividend_i[31:0]` by `divisor_i[15:0]`. It gives a 16-bit quotient and remainder.
- R6: Signed mode (`signed_i`=1) reads the operands as two's complement. The quotient is truncated toward zero, and the remainder carries the sign of the dividend. Results are two's complement at width N.
- R7: A zero divisor gives `fault_o`=1 at `done_o`, with `quot_o` and `rem_o` both 0.
- R8: In unsigned mode, a quotient above 2^N-1 gives `fault_o`=1, with zero results.
- R9: In signed mode, a quotient outside -2^(N-1)..2^(N-1)-1 gives `fault_o`=1, with zero results. The bound values themselves are accepted.
- R10: In narrow mode, `dividend_i[31:16]` and `divisor_i[15:8]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| signed_i | input | 1 | 1 = two's complement division |
| wide_i | input | 1 | 1 = 32/16 division, 0 = 16/8 division |
| dividend_i | input | 32 | Dividend (narrow mode uses [15:0]) |
| divisor_i | input | 16 | Divisor (narrow mode uses [7:0]) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid strobe, one cycle |
| quot_o | output | 16 | Quotient, held until the next completion |
| rem_o | output | 16 | Remainder, held until the next completion |
| fault_o | output | 1 | Divide fault, held with the results |

## Verification
Unsigned vectors in both widths exercise the plain shift-subtract loop. Among them, a quotient of exactly 255 sits next to 257, which separates the fit check from off-by-one errors. Signed vectors use every combination of operand signs, so a wrong quotient negation can be told apart from a wrong remainder sign. The boundary quotients -2^(N-1) and +2^(N-1) show whether the signed range test is asymmetric as it should be. Narrow-mode vectors carry junk in the unused upper input bits, and a second start pulse arrives during a run, to show that neither reaches the result.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: magnitudes, signs, early fault.
module div_prep #(
  parameter int DW = 16
) (
  input  logic            signed_i,
  input  logic            wide_i,
  input  logic [2*DW-1:0] dividend_i,
  input  logic [DW-1:0]   divisor_i,
  output logic [DW-1:0]   hi_mag_o,
  output logic [DW-1:0]   lo_mag_o,
  output logic [DW-1:0]   dvs_mag_o,
  output logic            dvd_neg_o,
  output logic            dvs_neg_o,
  output logic            pre_fault_o
);
  localparam int HW = DW / 2;

  logic [2*DW-1:0] dvd_ext, dvd_mag;
  logic [DW-1:0]   dvs_ext;

  always_comb begin
    dvd_neg_o = signed_i & (wide_i ? dividend_i[2*DW-1] : dividend_i[DW-1]);
    dvs_neg_o = signed_i & (wide_i ? divisor_i[DW-1] : divisor_i[HW-1]);

    dvd_ext = wide_i ? dividend_i
                     : {{DW{dvd_neg_o}}, dividend_i[DW-1:0]};
    dvd_mag = dvd_neg_o ? (~dvd_ext + 1'b1) : dvd_ext;

    dvs_ext   = wide_i ? divisor_i : {{HW{dvs_neg_o}}, divisor_i[HW-1:0]};
    dvs_mag_o = dvs_neg_o ? (~dvs_ext + 1'b1) : dvs_ext;

    if (wide_i) begin
      hi_mag_o = dvd_mag[2*DW-1:DW];
      lo_mag_o = dvd_mag[DW-1:0];
    end else begin
      // narrow: left-justify low half so the loop always shifts from the MSB
      hi_mag_o = {{HW{1'b0}}, dvd_mag[DW-1:HW]};
      lo_mag_o = {dvd_mag[HW-1:0], {HW{1'b0}}};
    end

    // quotient magnitude >= 2^N whenever the high part reaches the divisor
    pre_fault_o = (dvs_mag_o == '0) | (hi_mag_o >= dvs_mag_o);
  end
endmodule

// File: rtl/div_core.sv
// Restoring shift-subtract, one quotient bit per step.
module div_core #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] dvs_i,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o
);
  logic [DW-1:0] part_q, quo_q;
  logic [DW:0]   shifted, diff;
  logic          take;

  always_comb begin
    shifted = {part_q, quo_q[DW-1]};
    diff    = shifted - {1'b0, dvs_i};
    take    = shifted >= {1'b0, dvs_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q <= '0;
      quo_q  <= '0;
    end else if (load_i) begin
      part_q <= hi_i;
      quo_q  <= lo_i;
    end else if (step_i) begin
      part_q <= take ? diff[DW-1:0] : shifted[DW-1:0];
      quo_q  <= {quo_q[DW-2:0], take};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = part_q;
endmodule

// File: rtl/div_fix.sv
// Sign restore, range check and result masking.
module div_fix #(
  parameter int DW = 16
) (
  input  logic          wide_i,
  input  logic          signed_i,
  input  logic          qneg_i,
  input  logic          rneg_i,
  input  logic          pre_fault_i,
  input  logic [DW-1:0] q_mag_i,
  input  logic [DW-1:0] r_mag_i,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          fault_o
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] POS_WIDE   = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] POS_NARROW = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};

  logic [DW-1:0] mask, lim_pos, q_m, r_m, q_s, r_s;
  logic          range_bad;

  always_comb begin
    mask    = wide_i ? '1 : {{HW{1'b0}}, {HW{1'b1}}};
    lim_pos = wide_i ? POS_WIDE : POS_NARROW;
    q_m     = q_mag_i & mask;
    r_m     = r_mag_i & mask;
    // negative side reaches one further than the positive side
    range_bad = signed_i & (qneg_i ? (q_m > lim_pos + 1'b1) : (q_m > lim_pos));
    fault_o   = pre_fault_i | range_bad;
    q_s = qneg_i ? (~q_m + 1'b1) : q_m;
    r_s = rneg_i ? (~r_m + 1'b1) : r_m;
    quo_o = fault_o ? '0 : (q_s & mask);
    rem_o = fault_o ? '0 : (r_s & mask);
  end
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit #(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            signed_i,
  input  logic            wide_i,
  input  logic [2*DW-1:0] dividend_i,
  input  logic [DW-1:0]   divisor_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   quot_o,
  output logic [DW-1:0]   rem_o,
  output logic            fault_o
);
  import div_pkg::*;

  localparam int HW = DW / 2;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_WIDE   = CW'(DW);
  localparam logic [CW-1:0] CNT_NARROW = CW'(HW);

  div_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic wide_q, sgn_q, qneg_q, rneg_q, pf_q;
  logic [DW-1:0] dvs_q;
  logic done_q, fault_q;
  logic [DW-1:0] quot_q, rem_q;

  logic [DW-1:0] hi_mag, lo_mag, dvs_mag, core_quo, core_rem, fix_quo, fix_rem;
  logic dvd_neg, dvs_neg, pre_fault, fix_fault, accept, load, step;

  assign accept = start_i & (st_q == ST_IDLE);
  assign load   = accept;
  assign step   = (st_q == ST_RUN);

  div_prep #(.DW(DW)) u_prep (
    .signed_i   (signed_i),
    .wide_i     (wide_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .hi_mag_o   (hi_mag),
    .lo_mag_o   (lo_mag),
    .dvs_mag_o  (dvs_mag),
    .dvd_neg_o  (dvd_neg),
    .dvs_neg_o  (dvs_neg),
    .pre_fault_o(pre_fault)
  );

  div_core #(.DW(DW)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .hi_i  (hi_mag),
    .lo_i  (lo_mag),
    .dvs_i (dvs_q),
    .quo_o (core_quo),
    .rem_o (core_rem)
  );

  div_fix #(.DW(DW)) u_fix (
    .wide_i     (wide_q),
    .signed_i   (sgn_q),
    .qneg_i     (qneg_q),
    .rneg_i     (rneg_q),
    .pre_fault_i(pf_q),
    .q_mag_i    (core_quo),
    .r_mag_i    (core_rem),
    .quo_o      (fix_quo),
    .rem_o      (fix_rem),
    .fault_o    (fix_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wide_q <= 1'b0;
      sgn_q  <= 1'b0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      pf_q   <= 1'b0;
      dvs_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_RUN;
          cnt_q  <= wide_i ? CNT_WIDE : CNT_NARROW;
          wide_q <= wide_i;
          sgn_q  <= signed_i;
          qneg_q <= dvd_neg ^ dvs_neg;
          rneg_q <= dvd_neg;
          pf_q   <= pre_fault;
          dvs_q  <= dvs_mag;
        end
        ST_RUN: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) st_q <= ST_FIX;
        end
        ST_FIX:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      quot_q  <= '0;
      rem_q   <= '0;
    end else begin
      done_q <= (st_q == ST_FIX);
      if (st_q == ST_FIX) begin
        fault_q <= fix_fault;
        quot_q  <= fix_quo;
        rem_q   <= fix_rem;
      end
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign quot_o  = quot_q;
  assign rem_o   = rem_q;
  assign fault_o = fault_q;

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_start_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_busy_start_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q == ST_RUN) |=> ($stable(dvs_q) && $stable(wide_q) && $stable(sgn_q)));
  p_partial_below_divisor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !pf_q) |-> (core_rem < dvs_q));
  p_fault_zero_result_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (quot_o == '0 && rem_o == '0));
  p_narrow_upper_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_q) |-> (quot_o[DW-1:HW] == '0 && rem_o[DW-1:HW] == '0));
endmodule

// File: tb/tb_int_div_unit.sv
`timescale 1ns/1ps
module tb_int_div_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sgn = 1'b0, wide = 1'b0;
  logic [31:0] dvd = '0;
  logic [15:0] dvs = '0;
  logic        busy, done, fault;
  logic [15:0] quot, rem;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  int_div_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn), .wide_i(wide),
    .dividend_i(dvd), .divisor_i(dvs), .busy_o(busy), .done_o(done),
    .quot_o(quot), .rem_o(rem), .fault_o(fault)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  task automatic model(input bit s, input bit w, input logic [31:0] a_in,
                       input logic [15:0] b_in, output logic [15:0] eq,
                       output logic [15:0] er, output bit ef);
    longint a, b, q, r, n, lim;
    n = w ? 16 : 8;
    lim = longint'(1) << n;
    if (s) begin
      a = w ? longint'($signed(a_in)) : longint'($signed(a_in[15:0]));
      b = w ? longint'($signed(b_in)) : longint'($signed(b_in[7:0]));
    end else begin
      a = w ? longint'({32'b0, a_in}) : longint'({48'b0, a_in[15:0]});
      b = w ? longint'({48'b0, b_in}) : longint'({56'b0, b_in[7:0]});
    end
    ef = 0; q = 0; r = 0;
    if (b == 0) ef = 1;
    else begin
      q = a / b;
      r = a % b;
      if (s) ef = (q < -(lim / 2)) || (q > lim / 2 - 1);
      else   ef = (q > lim - 1);
    end
    if (ef) begin q = 0; r = 0; end
    eq = 16'(q & (lim - 1));
    er = 16'(r & (lim - 1));
  endtask

  task automatic run_op(input bit s, input bit w, input logic [31:0] a,
                        input logic [15:0] b, input bit glitch, input string tag);
    logic [15:0] eq, er;
    bit ef;
    int n;
    n = w ? 16 : 8;
    model(s, w, a, b, eq, er, ef);
    @(negedge clk);
    sgn = s; wide = w; dvd = a; dvs = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc <= n; cyc++) begin
      chk(busy === 1'b1 && done === 1'b0, "R2 busy window", {busy, done}, 2'b10);
      if (glitch && cyc == 3) begin
        start = 1'b1; sgn = ~s; wide = ~w; dvd = ~a; dvs = 16'h0001;
      end else if (glitch && cyc == 4) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(busy === 1'b0 && done === 1'b1, "R2 done strobe", {busy, done}, 2'b01);
    chk(fault === ef, {tag, " fault"}, fault, ef);
    chk(quot === eq, {tag, " quotient"}, quot, eq);
    chk(rem === er, {tag, " remainder"}, rem, er);
    @(negedge clk);
    chk(done === 1'b0, "R2 done single cycle", done, 0);
    chk(busy === 1'b0, "R3 no late restart", busy, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && fault === 0, "R1 reset flags", {busy, done, fault}, 0);
    chk(quot === 0 && rem === 0, "R1 reset results", {quot, rem}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(0, 0, 32'h0000_1234, 16'h0056, 0, "R4 u8");
    run_op(0, 0, 32'h0000_FEFF, 16'h00FF, 0, "R4 u8 max quotient");
    run_op(0, 0, 32'hABCD_1234, 16'hFF56, 0, "R10 u8 upper junk");
    run_op(0, 1, 32'h0012_3456, 16'h1234, 0, "R5 u16");
    run_op(0, 1, 32'hFFFE_0001, 16'hFFFF, 0, "R5 u16 max");
    run_op(1, 0, 32'h0000_FF9C, 16'h0007, 0, "R6 s8 neg/pos");
    run_op(1, 0, 32'h0000_0064, 16'h00F9, 0, "R6 s8 pos/neg");
    run_op(1, 0, 32'h0000_FF9C, 16'h00F9, 0, "R6 s8 neg/neg");
    run_op(1, 0, 32'h5555_FF9C, 16'h3307, 0, "R10 s8 upper junk");
    run_op(1, 1, 32'hFFF0_BDC0, 16'h012C, 0, "R6 s16 neg/pos");
    run_op(1, 1, 32'h000F_4240, 16'hFED4, 0, "R6 s16 pos/neg");
    run_op(0, 0, 32'h0000_1234, 16'hFF00, 0, "R7 zero divisor u8");
    run_op(1, 1, 32'h1234_5678, 16'h0000, 0, "R7 zero divisor s16");
    run_op(0, 0, 32'h0000_1000, 16'h0010, 0, "R8 u8 overflow 256");
    run_op(0, 0, 32'h0000_FFFF, 16'h00FF, 0, "R8 u8 overflow 257");
    run_op(0, 1, 32'h0001_0000, 16'h0001, 0, "R8 u16 overflow");
    run_op(1, 0, 32'h0000_FF00, 16'h0002, 0, "R9 s8 -128 accepted");
    run_op(1, 0, 32'h0000_0100, 16'h0002, 0, "R9 s8 +128 fault");
    run_op(1, 1, 32'hFFFF_0000, 16'h0002, 0, "R9 s16 -32768 accepted");
    run_op(1, 1, 32'h0001_0000, 16'h0002, 0, "R9 s16 +32768 fault");
    run_op(1, 0, 32'h0000_7FFF, 16'h00FF, 0, "R9 s8 large fault");
    run_op(0, 1, 32'h0012_3456, 16'h1234, 1, "R3 start ignored while busy");
    run_op(1, 0, 32'h0000_FF9C, 16'h0007, 1, "R3 start ignored signed");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule